// File: doc/BRIEF.md
# Full-Frame CCD Readout Clock Sequencer

This block produces the logic-level clock pattern that reads out a two-phase, full-frame CCD area sensor. A start pulse begins a frame. The block holds the shutter open for a programmable exposure time and keeps all array clocks idle during that time. It then closes the shutter and reads the array out. Each row transfer drives the first vertical phase and then the second. The transfer gate moves together with the second vertical phase. After a guard interval, the serial register is clocked out one pixel at a time. The two horizontal phases are exact logic complements. The summing gate moves with the second horizontal phase, and the reset gate opens at the start of every pixel period.

For each pixel the block emits a one-cycle sample strobe for the analog front end. The strobe carries the pixel position within the row and a flag that tells signal pixels from dummy pixels. A row holds a fixed sequence: a leading group of dummy pixels, then the active pixels, then a trailing group of dummy pixels. A frame holds the active rows followed by a group of dummy rows. Every pulse width, guard interval and count is a parameter in system-clock cycles. When the last pixel of the last row has been clocked out, a one-cycle done pulse marks the end of the frame and all outputs return low.

Top module: `ccd_seq_top`

## Requirements
- R1: While `rstN` is low, and in the idle state after reset, every output is 0.
- R2: A start pulse in idle drives `shutterOpen` high for exactly T_INTEG cycles. No array clock is active while the shutter is open. `vClk1` rises in the cycle after the last open cycle.
- R3: Each row transfer drives `vClk1` high for T_VPW cycles, then `vClk2` high for the next T_VPW cycles. `xferGate` equals `vClk2` on every cycle. The two vertical phases are never high together.
- R4: Each pixel period is 2·T_HPW cycles: `hClk1` is high for the first T_HPW cycles and `hClk2` for the last T_HPW cycles. While pixels are clocked, `hClk2` is always the inverse of `hClk1`. `sumGate` equals `hClk2` on every cycle.
- R5: After `vClk2` falls, all clocks stay low for exactly T_GUARD cycles before `hClk1` rises.
- R6: Each row yields N_LEAD_DUM + N_ACT_PIX + N_TRAIL_DUM strobes, with `smpIdx` counting from 0. `smpIsSignal` is 1 exactly for indices N_LEAD_DUM to N_LEAD_DUM+N_ACT_PIX-1, and 0 for the dummy indices before and after that range.
- R7: `rstGate` rises in the same cycle as `hClk1`, stays high for T_RPW cycles (T_RPW < T_HPW), and pulses once per pixel period.
- R8: `smpStrobe` is high for one cycle per pixel, in the last cycle of the `hClk2` half. `rstGate` is low in that cycle.
- R9: A frame contains N_ACT_LINES + N_DUM_LINES row transfers.
- R10: `frameDone` pulses for one cycle, in the cycle after the last `hClk2` half of the last row. All clocks and the shutter are low in that cycle, and the block then returns to idle.
- R11: A start pulse that arrives during exposure or readout is ignored. It neither restarts nor extends the frame, and no further frame follows it.
- R12: Two consecutive strobes are never closer than CLK_HZ / PIX_MAX_HZ cycles, so the pixel rate never exceeds PIX_MAX_HZ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start pulse, accepted only in idle |
| shutterOpen | output | 1 | High while the exposure runs |
| vClk1 | output | 1 | Vertical phase 1 |
| vClk2 | output | 1 | Vertical phase 2 |
| xferGate | output | 1 | Transfer gate, follows vertical phase 2 |
| hClk1 | output | 1 | Horizontal phase 1 |
| hClk2 | output | 1 | Horizontal phase 2 |
| sumGate | output | 1 | Summing gate, follows horizontal phase 2 |
| rstGate | output | 1 | Output-node reset gate |
| smpStrobe | output | 1 | One-cycle sample strobe per pixel |
| smpIdx | output | IDX_W | Pixel position within the row for the strobe |
| smpIsSignal | output | 1 | 1 for a signal pixel, 0 for a dummy pixel |
| frameDone | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions check on every cycle the properties that hold at each clock edge:
- the two vertical phases are never high together;
- the handover from vertical to horizontal phase is clean;
- the reset gate stays inside the first horizontal half;
- the strobe lands in the second half with the reset gate low;
- the shutter stays closed while any clock runs, and all clocks are quiet at done;
- strobes keep the minimum spacing.

Only the bench scenarios can show the exact lengths of the pulse, exposure and guard runs, the dummy/signal order of the pixel indices, the row count per frame, and that start pulses arriving during exposure or readout leave the frame unchanged. The bench uses a small configuration so that every row and pixel of several frames is checked.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_INTEG,
    S_V1,
    S_V2,
    S_GUARD,
    S_HPIX,
    S_DONE
  } seq_state_t;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic shut;
    logic v1;
    logic v2;
    logic hAct;
    logic h1;
    logic rst;
    logic smp;
    logic isSig;
    logic done;
  } seq_strb_t;

endpackage

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int N_ACT_LINES = 512,
  parameter int N_DUM_LINES = 8,
  parameter int N_LEAD_DUM  = 12,
  parameter int N_ACT_PIX   = 512,
  parameter int N_TRAIL_DUM = 8,
  parameter int IDX_W       = 10,
  parameter int T_VPW       = 12500,
  parameter int T_HPW       = 420,
  parameter int T_RPW       = 100,
  parameter int T_GUARD     = 200,
  parameter int T_INTEG     = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output seq_strb_t        strb,
  output logic [IDX_W-1:0] pixIdx
);

  localparam int NLINES  = N_ACT_LINES + N_DUM_LINES;
  localparam int NPIX    = N_LEAD_DUM + N_ACT_PIX + N_TRAIL_DUM;
  localparam int PIX_PER = 2 * T_HPW;
  localparam int LN_W    = (NLINES > 1) ? $clog2(NLINES) : 1;
  localparam int SIG_LO  = N_LEAD_DUM;
  localparam int SIG_HI  = N_LEAD_DUM + N_ACT_PIX;

  seq_state_t       st;
  logic [31:0]      cnt;
  logic [LN_W-1:0]  line;
  logic [IDX_W-1:0] pix;
  logic             phaseEnd;
  logic             lastPix;
  logic             lastLine;

  always_comb begin
    unique case (st)
      S_INTEG: phaseEnd = (cnt == 32'(T_INTEG - 1));
      S_V1,
      S_V2:    phaseEnd = (cnt == 32'(T_VPW - 1));
      S_GUARD: phaseEnd = (cnt == 32'(T_GUARD - 1));
      S_HPIX:  phaseEnd = (cnt == 32'(PIX_PER - 1));
      default: phaseEnd = 1'b1;
    endcase
  end

  assign lastPix  = (pix == IDX_W'(NPIX - 1));
  assign lastLine = (line == LN_W'(NLINES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st   <= S_IDLE;
      cnt  <= '0;
      line <= '0;
      pix  <= '0;
    end else if (st == S_IDLE) begin
      if (start) begin
        st  <= S_INTEG;
        cnt <= '0;
      end
    end else if (!phaseEnd) begin
      cnt <= cnt + 32'd1;
    end else begin
      cnt <= '0;
      unique case (st)
        S_INTEG: begin
          st   <= S_V1;
          line <= '0;
        end
        S_V1:    st <= S_V2;
        S_V2:    st <= S_GUARD;
        S_GUARD: begin
          st  <= S_HPIX;
          pix <= '0;
        end
        S_HPIX: begin
          if (!lastPix) begin
            pix <= pix + IDX_W'(1);
          end else if (lastLine) begin
            st <= S_DONE;
          end else begin
            line <= line + LN_W'(1);
            st   <= S_V1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb       = '0;
    strb.shut  = (st == S_INTEG);
    strb.v1    = (st == S_V1);
    strb.v2    = (st == S_V2);
    strb.hAct  = (st == S_HPIX);
    strb.h1    = (st == S_HPIX) && (cnt < 32'(T_HPW));
    strb.rst   = (st == S_HPIX) && (cnt < 32'(T_RPW));
    strb.smp   = (st == S_HPIX) && phaseEnd;
    strb.isSig = (pix >= IDX_W'(SIG_LO)) && (pix < IDX_W'(SIG_HI));
    strb.done  = (st == S_DONE);
  end

  assign pixIdx = pix;

endmodule

// File: rtl/ccd_seq_dp.sv
module ccd_seq_dp
  import ccd_seq_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_strb_t        strb,
  input  logic [IDX_W-1:0] pixIdxIn,
  output logic             shutterOpen,
  output logic             vClk1,
  output logic             vClk2,
  output logic             xferGate,
  output logic             hClk1,
  output logic             hClk2,
  output logic             sumGate,
  output logic             rstGate,
  output logic             smpStrobe,
  output logic [IDX_W-1:0] smpIdx,
  output logic             smpIsSignal,
  output logic             frameDone
);

  seq_strb_t        q;
  logic [IDX_W-1:0] idxQ;
  logic             h2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q    <= '0;
      idxQ <= '0;
    end else begin
      q    <= strb;
      idxQ <= pixIdxIn;
    end
  end

  // second horizontal phase is the exact inverse of the first while active
  assign h2 = q.hAct & ~q.h1;

  assign shutterOpen = q.shut;
  assign vClk1       = q.v1;
  assign vClk2       = q.v2;
  assign xferGate    = q.v2;
  assign hClk1       = q.h1;
  assign hClk2       = h2;
  assign sumGate     = h2;
  assign rstGate     = q.rst;
  assign smpStrobe   = q.smp;
  assign smpIdx      = q.smp ? idxQ : '0;
  assign smpIsSignal = q.smp & q.isSig;
  assign frameDone   = q.done;

endmodule

// File: rtl/ccd_seq_top.sv
module ccd_seq_top
  import ccd_seq_pkg::*;
#(
  parameter int N_ACT_LINES = 512,
  parameter int N_DUM_LINES = 8,
  parameter int N_LEAD_DUM  = 12,
  parameter int N_ACT_PIX   = 512,
  parameter int N_TRAIL_DUM = 8,
  parameter int IDX_W       = 10,
  parameter int T_VPW       = 12500,
  parameter int T_HPW       = 420,
  parameter int T_RPW       = 100,
  parameter int T_GUARD     = 200,
  parameter int T_INTEG     = 1000,
  parameter int CLK_HZ      = 125000000,
  parameter int PIX_MAX_HZ  = 150000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             shutterOpen,
  output logic             vClk1,
  output logic             vClk2,
  output logic             xferGate,
  output logic             hClk1,
  output logic             hClk2,
  output logic             sumGate,
  output logic             rstGate,
  output logic             smpStrobe,
  output logic [IDX_W-1:0] smpIdx,
  output logic             smpIsSignal,
  output logic             frameDone
);

  seq_strb_t        strb;
  logic [IDX_W-1:0] pixIdx;

  ccd_seq_ctrl #(
    .N_ACT_LINES(N_ACT_LINES), .N_DUM_LINES(N_DUM_LINES),
    .N_LEAD_DUM(N_LEAD_DUM), .N_ACT_PIX(N_ACT_PIX), .N_TRAIL_DUM(N_TRAIL_DUM),
    .IDX_W(IDX_W), .T_VPW(T_VPW), .T_HPW(T_HPW), .T_RPW(T_RPW),
    .T_GUARD(T_GUARD), .T_INTEG(T_INTEG)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strb(strb), .pixIdx(pixIdx)
  );

  ccd_seq_dp #(.IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pixIdxIn(pixIdx),
    .shutterOpen(shutterOpen), .vClk1(vClk1), .vClk2(vClk2),
    .xferGate(xferGate), .hClk1(hClk1), .hClk2(hClk2), .sumGate(sumGate),
    .rstGate(rstGate), .smpStrobe(smpStrobe), .smpIdx(smpIdx),
    .smpIsSignal(smpIsSignal), .frameDone(frameDone)
  );

endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk #(
  parameter int CLK_HZ     = 125000000,
  parameter int PIX_MAX_HZ = 150000
) (
  input logic clk,
  input logic rstN,
  input logic shutterOpen,
  input logic vClk1,
  input logic vClk2,
  input logic xferGate,
  input logic hClk1,
  input logic hClk2,
  input logic sumGate,
  input logic rstGate,
  input logic smpStrobe,
  input logic frameDone
);

  logic [31:0] sinceStrobe;
  logic        haveStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceStrobe <= '0;
      haveStrobe  <= 1'b0;
    end else if (smpStrobe) begin
      sinceStrobe <= 32'd1;
      haveStrobe  <= 1'b1;
    end else if (sinceStrobe != 32'hFFFF_FFFF) begin
      sinceStrobe <= sinceStrobe + 32'd1;
    end
  end

  a_r3_vert_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(vClk1 && vClk2));

  a_r3_vert_handover: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vClk1) |-> (vClk2 && xferGate));

  a_r4_horiz_handover: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hClk1) |-> (hClk2 && sumGate));

  a_r5_guard_after_vert: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vClk2) |-> !(hClk1 || hClk2));

  a_r7_reset_in_first_half: assert property (@(posedge clk) disable iff (!rstN)
    rstGate |-> (hClk1 && !hClk2));

  a_r8_strobe_placement: assert property (@(posedge clk) disable iff (!rstN)
    smpStrobe |-> (hClk2 && !rstGate));

  a_r2_shutter_closed_clocks: assert property (@(posedge clk) disable iff (!rstN)
    shutterOpen |-> !(vClk1 || vClk2 || hClk1 || hClk2));

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !(shutterOpen || vClk1 || vClk2 || hClk1 || hClk2 || rstGate));

  a_r12_pixel_rate: assert property (@(posedge clk) disable iff (!rstN)
    (smpStrobe && haveStrobe) |-> (64'(sinceStrobe) * 64'(PIX_MAX_HZ) >= 64'(CLK_HZ)));

endmodule

bind ccd_seq_top ccd_seq_chk #(.CLK_HZ(CLK_HZ), .PIX_MAX_HZ(PIX_MAX_HZ)) u_chk (
  .clk(clk), .rstN(rstN), .shutterOpen(shutterOpen), .vClk1(vClk1),
  .vClk2(vClk2), .xferGate(xferGate), .hClk1(hClk1), .hClk2(hClk2),
  .sumGate(sumGate), .rstGate(rstGate), .smpStrobe(smpStrobe),
  .frameDone(frameDone)
);

// File: tb/sim_ccd_seq_top.sv
`timescale 1ns/1ps
module sim_ccd_seq_top;

  localparam int NAL = 4, NDL = 2, LEAD = 3, ACT = 5, TRAIL = 2, IW = 10;
  localparam int TV = 3, TH = 2, TR = 1, TG = 2, TI = 5;
  localparam int CLKHZ = 600, PIXHZ = 150;
  localparam int NLINES = NAL + NDL;
  localparam int NPIX = LEAD + ACT + TRAIL;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic shutterOpen, vClk1, vClk2, xferGate, hClk1, hClk2, sumGate, rstGate;
  logic smpStrobe, smpIsSignal, frameDone;
  logic [IW-1:0] smpIdx;

  always #4 clk = ~clk;

  ccd_seq_top #(
    .N_ACT_LINES(NAL), .N_DUM_LINES(NDL), .N_LEAD_DUM(LEAD), .N_ACT_PIX(ACT),
    .N_TRAIL_DUM(TRAIL), .IDX_W(IW), .T_VPW(TV), .T_HPW(TH), .T_RPW(TR),
    .T_GUARD(TG), .T_INTEG(TI), .CLK_HZ(CLKHZ), .PIX_MAX_HZ(PIXHZ)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .shutterOpen(shutterOpen),
    .vClk1(vClk1), .vClk2(vClk2), .xferGate(xferGate), .hClk1(hClk1),
    .hClk2(hClk2), .sumGate(sumGate), .rstGate(rstGate), .smpStrobe(smpStrobe),
    .smpIdx(smpIdx), .smpIsSignal(smpIsSignal), .frameDone(frameDone)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit allQuiet();
    return !(shutterOpen || vClk1 || vClk2 || xferGate || hClk1 || hClk2 ||
             sumGate || rstGate || smpStrobe || frameDone || smpIsSignal || (smpIdx != 0));
  endfunction

  // monitor state
  bit monEn = 1'b0;
  int runShut = 0, runV1 = 0, runV2 = 0, runH1 = 0, runH2 = 0, runRg = 0;
  int gapCnt = 0, expIdx = 0, lines = 0, doneCnt = 0, shutRises = 0;
  int cyc = 0, lastStrobe = -1000;
  bit inGap = 1'b0;
  bit pShut = 0, pV1 = 0, pV2 = 0, pH1 = 0, pH2 = 0, pRg = 0;

  always @(negedge clk) begin
    cyc++;
    if (monEn) begin
      chk(xferGate == vClk2, "R3 xferGate", xferGate, vClk2);
      chk(sumGate == hClk2, "R4 sumGate", sumGate, hClk2);
      if (hClk1 || hClk2) chk(hClk1 != hClk2, "R4 complement", hClk2, !hClk1);

      // R2 exposure
      if (shutterOpen && !pShut) shutRises++;
      if (shutterOpen) runShut++;
      else if (pShut) begin
        chk(runShut == TI, "R2 exposure length", runShut, TI);
        chk(vClk1, "R2 readout follows", vClk1, 1);
        runShut = 0;
      end

      // R3 / R9 vertical
      if (vClk1 && !pV1) begin
        if (lines > 0) chk(expIdx == NPIX, "R6 strobes per row", expIdx, NPIX);
        expIdx = 0;
        lines++;
      end
      if (vClk1) runV1++;
      else if (pV1) begin
        chk(runV1 == TV, "R3 vClk1 width", runV1, TV);
        chk(vClk2, "R3 vClk2 follows", vClk2, 1);
        runV1 = 0;
      end
      if (vClk2) runV2++;
      else if (pV2) begin
        chk(runV2 == TV, "R3 vClk2 width", runV2, TV);
        runV2 = 0;
        inGap = 1'b1;
        gapCnt = 0;
      end

      // R5 guard
      if (inGap) begin
        if (hClk1) begin
          chk(gapCnt == TG, "R5 guard length", gapCnt, TG);
          inGap = 1'b0;
        end else if (!(vClk1 || vClk2 || hClk2 || rstGate)) gapCnt++;
      end

      // R4 horizontal
      if (hClk1) runH1++;
      else if (pH1) begin
        chk(runH1 == TH, "R4 hClk1 width", runH1, TH);
        chk(hClk2, "R4 hClk2 follows", hClk2, 1);
        runH1 = 0;
      end
      if (hClk2) runH2++;

      // R7 reset gate
      if (rstGate && !pRg) chk(hClk1 && !pH1, "R7 reset gate start", hClk1, 1);
      if (rstGate) runRg++;
      else if (pRg) begin
        chk(runRg == TR, "R7 reset gate width", runRg, TR);
        runRg = 0;
      end

      // R6 / R8 / R12 strobe
      if (smpStrobe) begin
        chk(smpIdx == IW'(expIdx), "R6 index", smpIdx, expIdx);
        chk(smpIsSignal == (expIdx >= LEAD && expIdx < LEAD + ACT), "R6 signal flag",
            smpIsSignal, (expIdx >= LEAD && expIdx < LEAD + ACT));
        chk(hClk2 && !rstGate && runH2 == TH, "R8 strobe placement", runH2, TH);
        chk((cyc - lastStrobe) * PIXHZ >= CLKHZ, "R12 strobe spacing", cyc - lastStrobe, CLKHZ / PIXHZ);
        lastStrobe = cyc;
        expIdx++;
      end
      if (!hClk2 && pH2) begin
        chk(runH2 == TH, "R4 hClk2 width", runH2, TH);
        runH2 = 0;
      end

      // R10 done
      if (frameDone) begin
        doneCnt++;
        chk(lines == NLINES, "R9 rows per frame", lines, NLINES);
        chk(expIdx == NPIX, "R6 strobes last row", expIdx, NPIX);
        chk(!(shutterOpen || vClk1 || vClk2 || hClk1 || hClk2 || rstGate), "R10 quiet at done", 1, 0);
        chk(pH2, "R10 done after last pixel", pH2, 1);
        lines = 0;
        expIdx = 0;
      end
    end
    pShut = shutterOpen; pV1 = vClk1; pV2 = vClk2; pH1 = hClk1; pH2 = hClk2; pRg = rstGate;
  end

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitDone(input int n);
    while (doneCnt < n) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(allQuiet(), "R1 outputs in reset", 0, 0);
    rstN = 1'b1;
    monEn = 1'b1;
    repeat (4) @(negedge clk);
    chk(allQuiet(), "R1 idle after reset", 0, 0);

    // frame 1: plain
    pulseStart();
    waitDone(1);
    chk(allQuiet(), "R10 idle after done", 0, 0);

    // frame 2: extra starts during exposure and readout
    pulseStart();
    repeat (2) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (60) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    waitDone(2);
    repeat (30) @(negedge clk);
    chk(shutRises == 2, "R11 no extra exposure", shutRises, 2);
    chk(doneCnt == 2, "R11 no extra frame", doneCnt, 2);
    chk(allQuiet(), "R11 idle after ignored starts", 0, 0);

    // frame 3: start again right after idle
    pulseStart();
    waitDone(3);
    chk(shutRises == 3, "R2 third exposure", shutRises, 3);

    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", doneCnt, 3);
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule